// File: doc/BRIEF.md
# Shared Timer Pin Toggle Output and Edge Capture

This block sits between two neighbouring interval timers and the single pin that they share. Each timer sends a one-cycle underflow strobe. The block turns each timer's strobes into a square wave at half the underflow rate. It then chooses what the pin drives: either the first timer's square wave, or the logical AND of both square waves.

The same pin can also serve as an external count source for the second timer. The block brings the pin level into the clock domain through a chain of synchronizing flops. It then emits a one-cycle count strobe for every rising edge it sees.

A single function bit decides whether the pin belongs to the timers, in which case it drives and the output enable is high, or is left to ordinary port logic, in which case the block does not drive it. The latch for the port mode lies outside this block.

Top module: `tpin_io`

## Requirements
- R1: After a synchronous active-low reset, both square-wave flops are 0, and the count strobe is 0.
- R2: An underflow strobe from the first timer, sampled high at a clock edge, inverts the first square wave at that edge. When the strobe is low, the wave holds its value.
- R3: An underflow strobe from the second timer, sampled high at a clock edge, inverts the second square wave at that edge. When the strobe is low, the wave holds its value.
- R4: When the pin function bit is 1 and the output select bit is 0, `pin_out` equals the first square wave.
- R5: When the pin function bit is 1 and the output select bit is 1, `pin_out` equals the AND of the first and second square waves.
- R6: When the pin function bit is 0, `pin_oe` is 0 and `pin_out` is 0. When the pin function bit is 1, `pin_oe` is 1. Both control bits act without a clock delay.
- R7: A 0-to-1 change on `pin_in` gives exactly one `ext_cnt_stb` pulse, one cycle wide, in the SYNC_STAGES-th cycle after the first clock edge that samples the high level. With the default of 2, a level applied before edge 1 raises the strobe after edge 2 and drops it after edge 3.
- R8: A falling edge, or a level held steady on `pin_in`, gives no count strobe.
- R9: The count strobe is produced in the same way for every setting of the pin function bit and the output select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uf_first | input | 1 | Underflow strobe from the first timer |
| uf_second | input | 1 | Underflow strobe from the second timer |
| pin_in | input | 1 | Level read from the shared pin, asynchronous to clk |
| pin_func_sel | input | 1 | 1: pin belongs to the timers; 0: pin is an ordinary port |
| out_sel | input | 1 | 0: drive the first wave; 1: drive the AND of both waves |
| pin_out | output | 1 | Value to drive on the pin |
| pin_oe | output | 1 | Output enable for the pin driver |
| ext_cnt_stb | output | 1 | One-cycle strobe on each synchronized rising edge of pin_in |

## Verification
The bench builds the block with its default depth of two synchronizer stages. This keeps the strobe delay fixed at two edges, so the exact cycle of each strobe can be checked. Over 512 cycles the bench steps through every combination of the two underflow strobes and the two control bits. It computes the expected pin value from running counts of the pulses it has issued.

Rising pulses on `pin_in` of one, two and six cycles are then applied under all four control settings. These cover strobe placement, the absence of a strobe on falling edges, and the absence of a strobe while a level is held.

// File: rtl/tpin_pkg.sv
// Shared types for the timer-pair pin block.
package tpin_pkg;
    // Output waveform selection; the bit value is decoded by the output mux.
    typedef enum logic {
        OSEL_FIRST = 1'b0,
        OSEL_AND   = 1'b1
    } osel_e;
endpackage

// File: rtl/tpin_toggle.sv
// Divide-by-2 flop: inverts its output on every underflow strobe.
// Assumes uf_stb is a synchronous single-cycle pulse.
module tpin_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_stb,
    output logic wave
);
    // Invert the square wave on each strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      wave <= 1'b0;
        else if (uf_stb) wave <= ~wave;
    end
endmodule

// File: rtl/tpin_edge_sync.sv
// Brings an asynchronous pin level into clk through SYNC_STAGES flops, then
// flags synchronized rising edges with a one-cycle strobe.
// Assumes SYNC_STAGES >= 1; two or more are needed for metastability margin.
module tpin_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise_stb
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] chain_q;
    logic         last_q;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            // Shift the pin level down the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[MSB-1:0], pin_in};
            end
        end else begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_in;
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[MSB];
    end

    // A rising edge is a synchronized high following a synchronized low.
    always_comb rise_stb = chain_q[MSB] & ~last_q;
endmodule

// File: rtl/tpin_out_mux.sv
// Chooses the pin drive value from the two square waves and gates it with the
// pin function bit. Purely combinational; the inputs come from flops.
module tpin_out_mux
    import tpin_pkg::*;
(
    input  logic  wave_first,
    input  logic  wave_second,
    input  osel_e sel,
    input  logic  pin_func,
    output logic  pin_out,
    output logic  pin_oe
);
    logic chosen;

    // Select either the first wave alone or the AND of both waves.
    always_comb begin
        unique case (sel)
            OSEL_AND: chosen = wave_first & wave_second;
            default:  chosen = wave_first;
        endcase
    end

    // Drive the pin and enable the driver only in the timer pin function.
    always_comb begin
        pin_oe  = pin_func;
        pin_out = pin_func & chosen;
    end
endmodule

// File: rtl/tpin_io.sv
// Top level of the shared timer pin: two divide-by-2 flops, the output
// selection and the rising-edge count strobe for the second timer.
// Assumes the underflow strobes are single-cycle pulses in the clk domain.
module tpin_io
    import tpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uf_first,
    input  logic uf_second,
    input  logic pin_in,
    input  logic pin_func_sel,
    input  logic out_sel,
    output logic pin_out,
    output logic pin_oe,
    output logic ext_cnt_stb
);
    localparam int NUM_TIMERS = 2;

    logic [NUM_TIMERS-1:0] uf_vec;
    logic [NUM_TIMERS-1:0] wave_vec;

    // Gather the underflow strobes; index 0 is the first timer.
    always_comb uf_vec = {uf_second, uf_first};

    generate
        for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tog
            tpin_toggle u_tog (
                .clk    (clk),
                .rst_n  (rst_n),
                .uf_stb (uf_vec[i]),
                .wave   (wave_vec[i])
            );
        end
    endgenerate

    tpin_out_mux u_mux (
        .wave_first  (wave_vec[0]),
        .wave_second (wave_vec[1]),
        .sel         (osel_e'(out_sel)),
        .pin_func    (pin_func_sel),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    tpin_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .rise_stb (ext_cnt_stb)
    );
endmodule

// File: rtl/tpin_io_chk.sv
// Property checker for tpin_io, attached through bind below.
module tpin_io_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       uf_first,
    input logic       uf_second,
    input logic       pin_func_sel,
    input logic       out_sel,
    input logic [1:0] wave_vec,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       ext_cnt_stb
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (wave_vec == 2'b00) && !ext_cnt_stb);

    // R2
    first_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_first |=> wave_vec[0] != $past(wave_vec[0]));

    // R2
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_first |=> $stable(wave_vec[0]));

    // R3
    second_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_second |=> wave_vec[1] != $past(wave_vec[1]));

    // R3
    second_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_second |=> $stable(wave_vec[1]));

    // R4
    sel_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_func_sel && !out_sel) |-> pin_out == wave_vec[0]);

    // R5
    sel_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_func_sel && out_sel) |-> pin_out == (wave_vec[0] & wave_vec[1]));

    // R6
    port_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_func_sel |-> !pin_oe && !pin_out);

    // R6
    timer_mode_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_func_sel |-> pin_oe);

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cnt_stb |=> !ext_cnt_stb);
endmodule

bind tpin_io tpin_io_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uf_first     (uf_first),
    .uf_second    (uf_second),
    .pin_func_sel (pin_func_sel),
    .out_sel      (out_sel),
    .wave_vec     (wave_vec),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .ext_cnt_stb  (ext_cnt_stb)
);

// File: tb/sim_tpin_io.sv
module sim_tpin_io;
    logic clk = 1'b0;
    logic rst_n, uf_first, uf_second, pin_in, pin_func_sel, out_sel;
    logic pin_out, pin_oe, ext_cnt_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tpin_io #(.SYNC_STAGES(2)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .uf_first     (uf_first),
        .uf_second    (uf_second),
        .pin_in       (pin_in),
        .pin_func_sel (pin_func_sel),
        .out_sel      (out_sel),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .ext_cnt_stb  (ext_cnt_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one rising pulse of the given width and check the strobe cycle by cycle.
    task automatic pulse_run(input int width, input bit func, input bit sel);
        pin_func_sel = func;
        out_sel      = sel;
        pin_in       = 1'b0;
        repeat (4) @(negedge clk);
        pin_in = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            #1;
            // R7 strobe only at k==2; R8 nothing on hold or fall; R9 any controls
            chk(k == 2 ? "R7" : (func || sel ? "R9" : "R8"), int'(ext_cnt_stb), (k == 2) ? 1 : 0);
            if (k == width) pin_in = 1'b0;
        end
    endtask

    initial begin
        int na = 0;
        int nb = 0;
        bit ea, eb, exp_out;
        rst_n = 1'b0; uf_first = 1'b0; uf_second = 1'b0; pin_in = 1'b0;
        pin_func_sel = 1'b1; out_sel = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", int'(pin_out), 0);
        chk("R1", int'(ext_cnt_stb), 0);
        chk("R6", int'(pin_oe), 1);
        out_sel = 1'b0;
        #1;
        chk("R1", int'(pin_out), 0);

        // Sweep strobes and controls; the counts give the expected waves.
        for (int cyc = 0; cyc < 512; cyc++) begin
            @(negedge clk);
            uf_first     = cyc[0] ^ cyc[5];
            uf_second    = cyc[1] ^ cyc[2];
            pin_func_sel = cyc[7] | cyc[3];
            out_sel      = cyc[6];
            #1;
            ea = na[0];
            eb = nb[0];
            if (!pin_func_sel) begin
                chk("R6", int'(pin_out), 0);
                chk("R6", int'(pin_oe), 0);
            end else if (!out_sel) begin
                exp_out = ea;
                chk("R2 R4", int'(pin_out), int'(exp_out));
                chk("R6", int'(pin_oe), 1);
            end else begin
                exp_out = ea & eb;
                chk("R3 R5", int'(pin_out), int'(exp_out));
                chk("R6", int'(pin_oe), 1);
            end
            if (uf_first)  na++;
            if (uf_second) nb++;
        end
        @(negedge clk);
        uf_first = 1'b0; uf_second = 1'b0;

        // Rising-edge strobe under every control setting.
        for (int c = 0; c < 4; c++) begin
            pulse_run(1, c[0], c[1]);
            pulse_run(2, c[0], c[1]);
            pulse_run(6, c[0], c[1]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule